// File: doc/BRIEF.md
# FFT Result Dump Handshake Controller

This block controls how a completed transform's results leave the output buffer. A one-cycle completion pulse queues a block descriptor. The descriptor holds three things captured at that pulse: the level of the active-low dump enable, the block size and the scale tag. The enable level picks one of two dump styles.

- **Strobe-paced automatic dump.** The output pipeline fills on output strobes. Data-available asserts on the strobe that completes the fill.
- **Host-gated dump.** The pipeline fills on the system clock. Data-available asserts without waiting for a strobe, and each host strobe moves one result only while the enable is low.

Results leave in natural bin order. The scale tag is shown beside them. Data-available falls on the strobe that carries the last word of a block. When the next block is already waiting, data-available stays inactive for one strobe and then returns with that block's first word. This one-strobe gap marks the block boundary.

The output buffer RAM is outside the block and has an asynchronous read port. The block supplies a word address and a bank bit. The bank bit alternates from one block to the next, starting at 0.

The outputs do not use real tri-state drivers. An output-enable signal marks when the result buses are valid, and the buses read zero whenever that enable is low. Data-available can optionally be held back by 24 extra strobes so that it lines up with a downstream stage.

Top module: `fftd_dump_ctrl`

## Requirements
- R1: After reset `dav_n` is 1, `out_oe` is 0, and `out_re`, `out_im` and `scale_out` are 0.
- R2: If `dump_en_n` is 0 at the completion pulse, the block uses strobe-paced mode. With the delay option off, `dav_n` falls on the second `ostb` after the pulse. The data bus then already shows word 0, and the next strobe transfers it.
- R3: `dav_n` returns to 1 on the strobe that transfers the last word of the block.
- R4: Suppose the next block is already queued and is strobe-paced, with the delay option off. Then `dav_n` stays 1 for exactly one strobe after the last transfer. It falls on the following strobe with word 0 of the new block on the bus.
- R5: If `dump_en_n` is 1 at the completion pulse, the block uses host-gated mode. `dav_n` falls two clock cycles after the pulse, with no strobe needed.
- R6: While `dav_n` is 0, a strobe with `dump_en_n` high transfers nothing. This holds in both modes.
- R7: `out_oe` is 1 only while `dav_n` and `dump_en_n` are both 0. Whenever `out_oe` is 0, `out_re` and `out_im` read 0.
- R8: `scale_out` shows the scale tag captured at that block's completion pulse while `dav_n` is 0, and reads 0 otherwise.
- R9: The k-th transfer of a block carries the buffer word at address k of that block's bank. The bank is 0 for the first block after reset and alternates for each later block.
- R10: With `dly_en` high, a strobe-paced block asserts `dav_n` 24 strobes after the strobe that would otherwise assert it. Host-gated blocks ignore `dly_en`.
- R11: `size_big` is captured at the completion pulse. A value of 0 gives a 256-word block and a value of 1 gives a 1024-word block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| xform_done | input | 1 | one-cycle pulse: a transformed block is ready |
| size_big | input | 1 | block size for the completing block (0: 256, 1: 1024) |
| dly_en | input | 1 | adds a 24-strobe delay before data-available |
| dump_en_n | input | 1 | dump enable, active low |
| ostb | input | 1 | output strobe, one clock-wide pulse per strobe edge |
| scale_in | input | 4 | scale tag of the completing block |
| rd_re | input | 16 | buffer read data, real part |
| rd_im | input | 16 | buffer read data, imaginary part |
| rd_addr | output | 10 | buffer word address |
| rd_bank | output | 1 | buffer bank being read |
| dav_n | output | 1 | data available, active low |
| out_oe | output | 1 | output buses valid (stands in for the tri-state enable) |
| out_re | output | 16 | result, real part |
| out_im | output | 16 | result, imaginary part |
| scale_out | output | 4 | scale tag of the block being dumped |

## Verification
The hardest case to reach is the block-boundary gap.

The second block must be queued while the first is still dumping, and before the fetcher passes the first block's last word. Only then is the pipeline already holding the new block's first word when the last transfer happens.

The bench reaches this state as follows:
1. It transfers ten words of a strobe-paced block.
2. It pulses completion with the enable low.
3. It drains the remaining words.
4. It checks that `dav_n` rises on the final strobe, falls on the very next strobe, and that the bus then holds word 0 from the other bank.

// File: rtl/fftd_pkg.sv
`timescale 1ns/1ps
package fftd_pkg;
    parameter int unsigned SCALE_W = 4;
    parameter int unsigned QDEPTH  = 2;
    localparam int unsigned QCW    = $clog2(QDEPTH + 1);

    typedef struct packed {
        logic               sync_mode;
        logic               big;
        logic [SCALE_W-1:0] scale;
    } blk_desc_t;
endpackage

// File: rtl/fftd_blk_queue.sv
`timescale 1ns/1ps
module fftd_blk_queue
    import fftd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  blk_desc_t          din,
    input  logic               pop,
    output logic [QCW-1:0]     cnt,
    output logic [QDEPTH-1:0]  q_sync,
    output logic [QDEPTH-1:0]  q_big,
    output logic [SCALE_W-1:0] head_scale
);
    typedef struct packed {
        blk_desc_t [QDEPTH-1:0] ent;
        logic [QCW-1:0]         cnt;
    } bq_t;

    bq_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (pop) begin
            for (int i = 0; i < int'(QDEPTH) - 1; i++) begin
                q_d.ent[i] = q_q.ent[i+1];
            end
            q_d.cnt = q_q.cnt - 1'b1;
        end
        if (push) begin
            for (int i = 0; i < int'(QDEPTH); i++) begin
                if (QCW'(i) == q_d.cnt) begin
                    q_d.ent[i] = din;
                end
            end
            q_d.cnt = q_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    genvar g;
    generate
        for (g = 0; g < int'(QDEPTH); g++) begin : g_flags
            assign q_sync[g] = q_q.ent[g].sync_mode;
            assign q_big[g]  = q_q.ent[g].big;
        end
    endgenerate

    assign cnt        = q_q.cnt;
    assign head_scale = q_q.ent[0].scale;
endmodule

// File: rtl/fftd_fetch.sv
`timescale 1ns/1ps
module fftd_fetch
    import fftd_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SMALL_LEN = 256,
    parameter int unsigned LARGE_LEN = 1024,
    parameter int unsigned PRIME     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [QCW-1:0]                q_cnt,
    input  logic [QDEPTH-1:0]             q_sync,
    input  logic [QDEPTH-1:0]             q_big,
    input  logic                          pop,
    input  logic                          strobe,
    input  logic                          xfer,
    input  logic [DATA_W-1:0]             rd_re,
    input  logic [DATA_W-1:0]             rd_im,
    output logic [$clog2(LARGE_LEN)-1:0]  rd_addr,
    output logic                          rd_bank,
    output logic                          head_vld,
    output logic                          head_vld_nx,
    output logic                          head_last,
    output logic [DATA_W-1:0]             head_re,
    output logic [DATA_W-1:0]             head_im
);
    localparam int unsigned AW   = $clog2(LARGE_LEN);
    localparam int unsigned HEAD = PRIME - 1;
    localparam logic [AW-1:0] SMALL_M1 = AW'(SMALL_LEN - 1);
    localparam logic [AW-1:0] LARGE_M1 = AW'(LARGE_LEN - 1);

    typedef struct packed {
        logic                           live;
        logic [AW-1:0]                  idx;
        logic                           bank;
        logic                           sync_mode;
        logic                           big;
        logic [QCW-1:0]                 started;
        logic [PRIME-1:0]               vld;
        logic [PRIME-1:0]               last;
        logic [PRIME-1:0][DATA_W-1:0]   re;
        logic [PRIME-1:0][DATA_W-1:0]   im;
    } fst_t;

    fst_t q_q, q_d;

    logic          can_start, pick_sync, pick_big;
    logic          eff_live, eff_bank, eff_sync, eff_big, eff_last;
    logic [AW-1:0] eff_idx;
    logic          pace, shift;

    always_comb begin
        pick_sync = q_sync[0];
        pick_big  = q_big[0];
        for (int i = 0; i < int'(QDEPTH); i++) begin
            if (QCW'(i) == q_q.started) begin
                pick_sync = q_sync[i];
                pick_big  = q_big[i];
            end
        end
        can_start = !q_q.live && (q_q.started < q_cnt);
        eff_live  = q_q.live | can_start;
        eff_idx   = can_start ? '0 : q_q.idx;
        eff_bank  = can_start ? ~q_q.bank : q_q.bank;
        eff_sync  = can_start ? pick_sync : q_q.sync_mode;
        eff_big   = can_start ? pick_big  : q_q.big;
        eff_last  = eff_idx == (eff_big ? LARGE_M1 : SMALL_M1);
        pace      = !q_q.vld[HEAD] && eff_live && (eff_sync ? strobe : 1'b1);
        shift     = xfer | pace;

        q_d = q_q;
        if (can_start) begin
            q_d.live      = 1'b1;
            q_d.idx       = '0;
            q_d.bank      = eff_bank;
            q_d.sync_mode = eff_sync;
            q_d.big       = eff_big;
            q_d.started   = q_q.started + 1'b1;
        end
        if (pop) begin
            q_d.started = q_d.started - 1'b1;
        end
        if (shift) begin
            for (int i = int'(HEAD); i > 0; i--) begin
                q_d.vld[i]  = q_q.vld[i-1];
                q_d.last[i] = q_q.last[i-1];
                q_d.re[i]   = q_q.re[i-1];
                q_d.im[i]   = q_q.im[i-1];
            end
            q_d.vld[0]  = eff_live;
            q_d.last[0] = eff_live && eff_last;
            q_d.re[0]   = rd_re;
            q_d.im[0]   = rd_im;
            if (eff_live) begin
                if (eff_last) begin
                    q_d.live = 1'b0;
                    q_d.idx  = '0;
                end else begin
                    q_d.idx = eff_idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q      <= '0;
            q_q.bank <= 1'b1;
        end else begin
            q_q <= q_d;
        end
    end

    assign rd_addr     = eff_idx;
    assign rd_bank     = eff_bank;
    assign head_vld    = q_q.vld[HEAD];
    assign head_vld_nx = q_d.vld[HEAD];
    assign head_last   = q_q.last[HEAD];
    assign head_re     = q_q.re[HEAD];
    assign head_im     = q_q.im[HEAD];
endmodule

// File: rtl/fftd_dav_ctrl.sv
`timescale 1ns/1ps
module fftd_dav_ctrl #(
    parameter int unsigned DLY = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic den_n,
    input  logic dly_en,
    input  logic have_blk,
    input  logic head_sync,
    input  logic head_vld,
    input  logic head_vld_nx,
    input  logic head_last,
    output logic dav,
    output logic xfer,
    output logic pop
);
    localparam int unsigned DCW = $clog2(DLY + 2);
    localparam logic [DCW-1:0] DLY_M1 = DCW'(DLY - 1);
    localparam bit HAS_DLY = DLY > 0;

    typedef struct packed {
        logic           dav;
        logic [DCW-1:0] dcnt;
    } dav_t;

    dav_t q_q, q_d;

    always_comb begin
        xfer = strobe && q_q.dav && !den_n;
        pop  = xfer && head_last;
        q_d  = q_q;
        if (q_q.dav) begin
            if (pop) begin
                q_d.dav  = 1'b0;
                q_d.dcnt = '0;
            end
        end else if (have_blk) begin
            if (head_sync) begin
                if (strobe) begin
                    if (HAS_DLY && dly_en) begin
                        if (head_vld) begin
                            if (q_q.dcnt == DLY_M1) begin
                                q_d.dav  = 1'b1;
                                q_d.dcnt = '0;
                            end else begin
                                q_d.dcnt = q_q.dcnt + 1'b1;
                            end
                        end
                    end else if (head_vld_nx) begin
                        q_d.dav = 1'b1;
                    end
                end
            end else if (head_vld_nx) begin
                q_d.dav = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign dav = q_q.dav;
endmodule

// File: rtl/fftd_dump_ctrl.sv
`timescale 1ns/1ps
module fftd_dump_ctrl
    import fftd_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SMALL_LEN = 256,
    parameter int unsigned LARGE_LEN = 1024,
    parameter int unsigned PRIME     = 2,
    parameter int unsigned DLY       = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         xform_done,
    input  logic                         size_big,
    input  logic                         dly_en,
    input  logic                         dump_en_n,
    input  logic                         ostb,
    input  logic [SCALE_W-1:0]           scale_in,
    input  logic [DATA_W-1:0]            rd_re,
    input  logic [DATA_W-1:0]            rd_im,
    output logic [$clog2(LARGE_LEN)-1:0] rd_addr,
    output logic                         rd_bank,
    output logic                         dav_n,
    output logic                         out_oe,
    output logic [DATA_W-1:0]            out_re,
    output logic [DATA_W-1:0]            out_im,
    output logic [SCALE_W-1:0]           scale_out
);
    localparam int unsigned AW = $clog2(LARGE_LEN);

    logic [QCW-1:0]     q_cnt;
    logic [QDEPTH-1:0]  q_sync, q_big;
    logic [SCALE_W-1:0] head_scale;
    logic               push, pop, xfer, dav, head_sync;
    logic               head_vld, head_vld_nx, head_last;
    logic [DATA_W-1:0]  head_re, head_im;
    blk_desc_t          new_desc;

    assign push      = xform_done && (q_cnt < QCW'(QDEPTH));
    assign new_desc  = '{sync_mode: !dump_en_n, big: size_big, scale: scale_in};
    assign head_sync = q_sync[0];

    fftd_blk_queue u_queue (
        .clk(clk), .rst_n(rst_n), .push(push), .din(new_desc), .pop(pop),
        .cnt(q_cnt), .q_sync(q_sync), .q_big(q_big), .head_scale(head_scale)
    );

    fftd_fetch #(
        .DATA_W(DATA_W), .SMALL_LEN(SMALL_LEN), .LARGE_LEN(LARGE_LEN), .PRIME(PRIME)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .q_cnt(q_cnt), .q_sync(q_sync), .q_big(q_big),
        .pop(pop), .strobe(ostb), .xfer(xfer), .rd_re(rd_re), .rd_im(rd_im),
        .rd_addr(rd_addr), .rd_bank(rd_bank), .head_vld(head_vld),
        .head_vld_nx(head_vld_nx), .head_last(head_last),
        .head_re(head_re), .head_im(head_im)
    );

    fftd_dav_ctrl #(.DLY(DLY)) u_dav (
        .clk(clk), .rst_n(rst_n), .strobe(ostb), .den_n(dump_en_n), .dly_en(dly_en),
        .have_blk(q_cnt != '0), .head_sync(head_sync), .head_vld(head_vld),
        .head_vld_nx(head_vld_nx), .head_last(head_last),
        .dav(dav), .xfer(xfer), .pop(pop)
    );

    assign dav_n     = !dav;
    assign out_oe    = dav && !dump_en_n;
    assign out_re    = out_oe ? head_re : '0;
    assign out_im    = out_oe ? head_im : '0;
    assign scale_out = dav ? head_scale : '0;
endmodule

// File: rtl/fftd_dump_ctrl_chk.sv
`timescale 1ns/1ps
module fftd_dump_ctrl_chk #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned AW      = 10,
    parameter int unsigned SCALE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ostb,
    input logic               dump_en_n,
    input logic               dav_n,
    input logic               out_oe,
    input logic [DATA_W-1:0]  out_re,
    input logic [DATA_W-1:0]  out_im,
    input logic [SCALE_W-1:0] scale_out,
    input logic [AW-1:0]      rd_addr,
    input logic               head_sync
);
    AST_SYNC_DAV_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dav_n) && head_sync) |-> $past(ostb)); // R2
    AST_DAV_DROP_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dav_n) |-> $past(ostb && !dump_en_n)); // R3
    AST_GATED_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dav_n && dump_en_n) |=> $stable(rd_addr)); // R6
    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dav_n |-> (!out_oe && out_re == '0 && out_im == '0)); // R7
    AST_SCALE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dav_n && $past(!dav_n)) |-> $stable(scale_out)); // R8
    AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != $past(rd_addr)) |-> (rd_addr == $past(rd_addr) + 1'b1 || rd_addr == '0)); // R9
endmodule

bind fftd_dump_ctrl fftd_dump_ctrl_chk #(
    .DATA_W(DATA_W), .AW(AW), .SCALE_W(fftd_pkg::SCALE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ostb(ostb), .dump_en_n(dump_en_n), .dav_n(dav_n),
    .out_oe(out_oe), .out_re(out_re), .out_im(out_im), .scale_out(scale_out),
    .rd_addr(rd_addr), .head_sync(head_sync)
);

// File: tb/sim_fftd_dump_ctrl.sv
`timescale 1ns/1ps
module sim_fftd_dump_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xform_done = 1'b0, size_big = 1'b0, dly_en = 1'b0;
    logic        dump_en_n = 1'b0, ostb = 1'b0;
    logic [3:0]  scale_in = '0;
    logic [15:0] rd_re, rd_im, out_re, out_im;
    logic [9:0]  rd_addr;
    logic        rd_bank, dav_n, out_oe;
    logic [3:0]  scale_out;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign rd_re = {rd_bank, 5'd0, rd_addr};
    assign rd_im = {rd_addr, 6'h2A};

    fftd_dump_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .xform_done(xform_done), .size_big(size_big),
        .dly_en(dly_en), .dump_en_n(dump_en_n), .ostb(ostb), .scale_in(scale_in),
        .rd_re(rd_re), .rd_im(rd_im), .rd_addr(rd_addr), .rd_bank(rd_bank),
        .dav_n(dav_n), .out_oe(out_oe), .out_re(out_re), .out_im(out_im),
        .scale_out(scale_out)
    );

    function automatic logic [31:0] exp_word(input logic bank, input int k);
        logic [9:0] kk;
        kk = k[9:0];
        return {bank, 5'd0, kk, kk, 6'h2A};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe();
        ostb = 1'b1;
        tick();
        ostb = 1'b0;
    endtask

    task automatic issue_done(input bit sync_sel, input bit big, input logic [3:0] sc);
        dump_en_n  = !sync_sel;
        size_big   = big;
        scale_in   = sc;
        xform_done = 1'b1;
        tick();
        xform_done = 1'b0;
    endtask

    // transfers words k0..k1-1; each word checked before its strobe (R9)
    task automatic drain(input logic bank, input int k0, input int k1, input logic [3:0] sc);
        for (int k = k0; k < k1; k++) begin
            chk(!dav_n && out_oe && {out_re, out_im} == exp_word(bank, k) && scale_out == sc,
                "R9", $sformatf("word %0d", k), {dav_n, scale_out, out_re, out_im},
                {1'b0, sc, exp_word(bank, k)});
            strobe();
            tick();
        end
    endtask

    task automatic t_reset();
        chk(dav_n && !out_oe && out_re == 0 && out_im == 0 && scale_out == 0, "R1",
            "reset state", {dav_n, out_oe, out_re}, 64'h2_0000);
    endtask

    task automatic t_sync_basic();
        issue_done(1'b1, 1'b0, 4'h5);
        tick();
        strobe();
        chk(dav_n == 1'b1, "R2", "dav after one strobe", dav_n, 1);
        tick();
        strobe();
        chk(dav_n == 1'b0, "R2", "dav after priming", dav_n, 0);
        chk({out_re, out_im} == exp_word(1'b0, 0), "R2", "word 0 ready", {out_re, out_im},
            exp_word(1'b0, 0));
        chk(scale_out == 4'h5, "R8", "scale tag", scale_out, 5);
        chk(out_oe == 1'b1, "R7", "oe active", out_oe, 1);
        dump_en_n = 1'b1;
        tick();
        chk(!out_oe && out_re == 0 && out_im == 0, "R7", "bus quiet with enable high",
            {out_oe, out_re}, 0);
        strobe();
        dump_en_n = 1'b0;
        tick();
        chk({out_re, out_im} == exp_word(1'b0, 0), "R6", "gated strobe moved nothing",
            {out_re, out_im}, exp_word(1'b0, 0));
        drain(1'b0, 0, 256, 4'h5);
        chk(dav_n == 1'b1, "R3", "dav after last word (R11 256)", dav_n, 1);
        chk(scale_out == 0 && !out_oe, "R8", "scale cleared", scale_out, 0);
    endtask

    task automatic t_host();
        issue_done(1'b0, 1'b0, 4'hA);
        tick();
        chk(dav_n == 1'b1, "R5", "dav one cycle after done", dav_n, 1);
        tick();
        chk(dav_n == 1'b0, "R5", "dav without strobes", dav_n, 0);
        chk(!out_oe && out_re == 0, "R7", "host bus quiet", {out_oe, out_re}, 0);
        chk(scale_out == 4'hA, "R8", "host scale tag", scale_out, 4'hA);
        for (int i = 0; i < 3; i++) begin
            strobe();
            tick();
        end
        dump_en_n = 1'b0;
        tick();
        chk({out_re, out_im} == exp_word(1'b1, 0), "R6", "host strobes gated",
            {out_re, out_im}, exp_word(1'b1, 0));
        drain(1'b1, 0, 256, 4'hA);
        chk(dav_n == 1'b1, "R3", "host last word", dav_n, 1);
    endtask

    task automatic t_delay();
        dly_en = 1'b1;
        issue_done(1'b1, 1'b1, 4'h9);
        tick();
        for (int s = 1; s <= 25; s++) begin
            strobe();
            tick();
        end
        chk(dav_n == 1'b1, "R10", "dav held after 25 strobes", dav_n, 1);
        strobe();
        chk(dav_n == 1'b0, "R10", "dav after 26 strobes", dav_n, 0);
        tick();
        drain(1'b0, 0, 1024, 4'h9);
        chk(dav_n == 1'b1, "R11", "1024-word block end", dav_n, 1);
        dly_en = 1'b0;
    endtask

    task automatic t_back2back();
        issue_done(1'b1, 1'b0, 4'h3);
        tick();
        strobe();
        tick();
        strobe();
        chk(dav_n == 1'b0, "R2", "first block primed", dav_n, 0);
        tick();
        drain(1'b1, 0, 10, 4'h3);
        issue_done(1'b1, 1'b0, 4'h7);
        drain(1'b1, 10, 255, 4'h3);
        strobe();
        chk(dav_n == 1'b1, "R4", "marker after last word", dav_n, 1);
        tick();
        strobe();
        chk(dav_n == 1'b0, "R4", "dav back after one strobe", dav_n, 0);
        chk({out_re, out_im} == exp_word(1'b0, 0), "R4", "next block word 0",
            {out_re, out_im}, exp_word(1'b0, 0));
        chk(scale_out == 4'h7, "R8", "next block scale", scale_out, 7);
        tick();
        drain(1'b0, 0, 256, 4'h7);
        chk(dav_n == 1'b1, "R3", "second block end", dav_n, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sync_basic();
        t_host();
        t_delay();
        t_back2back();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule